// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models the command side of a parallel NOR flash. The flash sits behind a plain synchronous bus with an address, write data, an access byte count and read data. The array itself is a small bank of byte registers. Writes carry command codes in their low byte, and these codes move a state machine between array read, identifier read, query, program, erase, lock setup and status. The state then decides what a read returns: array bytes, identifier words, bytes of a self-describing query table, or the status byte.

Programming is single-word and can only clear bits. Erase fills one whole block with ones in a single cycle. Lock commands are accepted but no lock bits are kept. A driver first probes the part through the identifier and query states, then issues program and erase sequences and polls status. It returns to array reads with a read-array or reset command.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read state. The status byte is 0x80 (bit 7 ready, bit 5 erase error, bit 4 program error), and every array byte reads 0xFF.
- R2: A write whose `nbytes_i` differs from `BUS_BYTES` changes neither state, status nor array.
- R3: In program state, the next accepted write ANDs each data byte into the array at offset+i, with byte i taken from `wdata_i[8i+7:8i]` (little-endian). The block then enters status state, and this holds whatever the data is.
- R4: Outside program state, an accepted write of 0xFF or 0xF0 returns the block to array-read state.
- R5: From array-read or identifier state, 0x98 enters query state only when the normalised address equals 0x55; otherwise the state is unchanged. 0x90 enters identifier state.
- R6: From array-read or identifier state, 0x20 enters erase state, 0x40 or 0x10 enters program state, 0x60 enters lock-setup state, and 0x50 sets status back to 0x80. In status and query state, every code other than 0xFF/0xF0 is ignored.
- R7: In erase state, 0xD0 sets the whole `BLK_BYTES`-aligned block holding the address to 0xFF and clears status bits 5 and 4. Any other code sets both bits. Both cases go to status state.
- R8: In lock-setup state, 0x01, 0xD0 and 0x2F leave the status unchanged and touch no array byte. Any other code sets status bits 5 and 4. Both cases go to status state.
- R9: In identifier state, reads at normalised offset 0 return `MANU_ID`, at 1 return 0x00AD, at 2 return 0, and at 5 return 0x8000. Only the low 9 offset bits are decoded.
- R10: In query state, normalised offset 0x10+k returns query byte k in bits 7:0 with the upper bits zero. Bytes 0..2 are "QRY", bytes 3..4 are `CMDSET_ID`, byte 23 is log2 of the array size, and byte 28 is the region count (1). Bytes 29..32 are the block count minus one and the block size over 256, both 16-bit little-endian. Offsets outside this table read 0.
- R11: In status or erase state, a read returns the status byte. In program or lock-setup state, a read returns 0.
- R12: The address is shifted right by log2(`BUS_BYTES`) before command and table decoding. `rdata_o` and `rvalid_o` update on the clock edge that samples `rd_en_i`, and `rvalid_o` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address into the array |
| wdata_i | input | 32 | Write data; the low byte carries commands |
| nbytes_i | input | 3 | Byte count of the access |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |

## Verification
A wrong state shows up on the first read after the command that caused it, because the state alone picks the read source. A stale status state returns 0x0080 where array data was expected, and a missed query entry returns array bytes instead of 0x51. Wrong status flags appear on the next status-state read, one cycle after `rd_en_i`. Array damage from a wrong erase boundary or a program that sets bits stays hidden until a later array read, so the sequences reread neighbouring blocks and reprogram words that were already programmed.

// File: rtl/nor_pkg.sv
package nor_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_READ_ID, ST_QUERY, ST_PROTECT, ST_STATUS, ST_ERASE, ST_PROG
  } nor_state_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RESET      = 8'hF0;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_QUERY      = 8'h98;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0; // erase confirm and unlock
  localparam logic [7:0] CMD_PROG       = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT   = 8'h10;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
  localparam logic [7:0] CMD_LOCK       = 8'h01;
  localparam logic [7:0] CMD_LOCKDOWN   = 8'h2F;

  localparam int SR_READY     = 7;
  localparam int SR_ERASE_ERR = 5;
  localparam int SR_PROG_ERR  = 4;
  localparam logic [7:0] SR_IDLE = 8'h80;
  localparam logic [7:0] SR_ERRS = 8'h30;

  localparam int QUERY_ENTRY = 'h55;
  localparam int QUERY_BASE  = 'h10;

  localparam logic [15:0] DEV_CODE = 16'h00AD;
  localparam logic [15:0] CFG_WORD = 16'h8000;
endpackage

// File: rtl/nor_addr_norm.sv
module nor_addr_norm #(
  parameter int ADDR_W    = 9,
  parameter int BUS_BYTES = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] offset_o,
  output logic [ADDR_W-1:0] shifted_o
);
  assign offset_o = addr_i;
  generate
    if (BUS_BYTES == 4) begin : g_w4
      assign shifted_o = addr_i >> 2;
    end else if (BUS_BYTES == 2) begin : g_w2
      assign shifted_o = addr_i >> 1;
    end else begin : g_w1
      assign shifted_o = addr_i;
    end
  endgenerate
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int BUS_BYTES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        nbytes_i,
  input  logic [7:0]        cmd_i,
  input  logic [ADDR_W-1:0] shifted_i,
  output nor_state_e        state_o,
  output logic [7:0]        status_o,
  output logic              prog_o,
  output logic              erase_o
);
  nor_state_e state_q;
  logic [7:0] status_q;
  logic       wr_ok;
  logic       lock_ok;

  assign wr_ok   = wr_en_i && (nbytes_i == 3'(BUS_BYTES));
  assign lock_ok = (cmd_i == CMD_LOCK) || (cmd_i == CMD_CONFIRM) || (cmd_i == CMD_LOCKDOWN);
  assign prog_o  = wr_ok && (state_q == ST_PROG);
  assign erase_o = wr_ok && (state_q == ST_ERASE) && (cmd_i == CMD_CONFIRM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_READ;
      status_q <= SR_IDLE;
    end else if (wr_ok) begin
      if (state_q == ST_PROG) begin
        state_q <= ST_STATUS;
      end else if (cmd_i == CMD_READ_ARRAY || cmd_i == CMD_RESET) begin
        state_q <= ST_READ;
      end else begin
        case (state_q)
          ST_READ, ST_READ_ID: begin
            case (cmd_i)
              CMD_QUERY: if (shifted_i == ADDR_W'(QUERY_ENTRY)) state_q <= ST_QUERY;
              CMD_READ_ID:             state_q  <= ST_READ_ID;
              CMD_ERASE:               state_q  <= ST_ERASE;
              CMD_PROG, CMD_PROG_ALT:  state_q  <= ST_PROG;
              CMD_LOCK_SETUP:          state_q  <= ST_PROTECT;
              CMD_CLR_STATUS:          status_q <= SR_IDLE;
              default: ;
            endcase
          end
          ST_ERASE: begin
            if (cmd_i == CMD_CONFIRM) status_q <= status_q & ~SR_ERRS;
            else                      status_q <= status_q | SR_ERRS;
            state_q <= ST_STATUS;
          end
          ST_PROTECT: begin
            if (!lock_ok) status_q <= status_q | SR_ERRS;
            state_q <= ST_STATUS;
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o  = state_q;
  assign status_o = status_q;
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int ADDR_W    = 9,
  parameter int BUS_BYTES = 2,
  parameter int BLK_BYTES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       word_o
);
  localparam int ARR_BYTES = 1 << ADDR_W;
  localparam int BLK_W     = $clog2(BLK_BYTES);

  logic [7:0] mem_q [ARR_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < ARR_BYTES; j++) mem_q[j] <= 8'hFF;
    end else if (prog_i) begin
      for (int i = 0; i < BUS_BYTES; i++)
        mem_q[offset_i + ADDR_W'(i)] <= mem_q[offset_i + ADDR_W'(i)] & wdata_i[8*i +: 8];
    end else if (erase_i) begin
      for (int j = 0; j < ARR_BYTES; j++) begin
        if (ADDR_W'(j) >> BLK_W == offset_i >> BLK_W) mem_q[j] <= 8'hFF;
      end
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_rd
    if (b < BUS_BYTES) begin : g_on
      assign word_o[8*b +: 8] = mem_q[offset_i + ADDR_W'(b)];
    end else begin : g_off
      assign word_o[8*b +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
  import nor_pkg::*;
#(
  parameter int          ADDR_W    = 9,
  parameter int          BUS_BYTES = 2,
  parameter int          BLK_BYTES = 256,
  parameter logic [15:0] MANU_ID   = 16'h0089,
  parameter logic [15:0] CMDSET_ID = 16'h0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  nor_state_e        state_i,
  input  logic [7:0]        status_i,
  input  logic [ADDR_W-1:0] shifted_i,
  input  logic [31:0]       array_word_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int          NUM_BLK  = (1 << ADDR_W) / BLK_BYTES;
  localparam int          QRY_LEN  = 29 + 4;
  localparam logic [15:0] BLK_M1   = 16'(NUM_BLK - 1);
  localparam logic [15:0] BLK_UNIT = 16'(BLK_BYTES / 256);
  localparam logic [31:0] BUS_MASK = (BUS_BYTES == 4) ? 32'hFFFF_FFFF :
                                     (BUS_BYTES == 2) ? 32'h0000_FFFF : 32'h0000_00FF;

  function automatic logic [7:0] qry_byte(input int k);
    case (k)
      0:  qry_byte = 8'h51;
      1:  qry_byte = 8'h52;
      2:  qry_byte = 8'h59;
      3:  qry_byte = CMDSET_ID[7:0];
      4:  qry_byte = CMDSET_ID[15:8];
      23: qry_byte = 8'(ADDR_W);
      28: qry_byte = 8'd1;
      29: qry_byte = BLK_M1[7:0];
      30: qry_byte = BLK_M1[15:8];
      31: qry_byte = BLK_UNIT[7:0];
      32: qry_byte = BLK_UNIT[15:8];
      default: qry_byte = 8'h00;
    endcase
  endfunction

  logic [31:0] sh32;
  logic [31:0] id_word;
  logic [31:0] rd_next;

  assign sh32 = 32'(shifted_i);

  always_comb begin
    case (sh32[8:0])
      9'd0:    id_word = {16'h0, MANU_ID};
      9'd1:    id_word = {16'h0, DEV_CODE};
      9'd5:    id_word = {16'h0, CFG_WORD};
      default: id_word = 32'h0;
    endcase
  end

  always_comb begin
    rd_next = 32'h0;
    case (state_i)
      ST_READ:    rd_next = array_word_i;
      ST_READ_ID: rd_next = id_word & BUS_MASK;
      ST_QUERY: begin
        if (sh32 >= 32'(QUERY_BASE) && sh32 < 32'(QUERY_BASE + QRY_LEN))
          rd_next = {24'h0, qry_byte(int'(sh32) - QUERY_BASE)};
      end
      ST_STATUS, ST_ERASE: rd_next = {24'h0, status_i};
      default: rd_next = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= 32'h0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_next;
    end
  end
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_pkg::*;
#(
  parameter int          ADDR_W    = 9,
  parameter int          BUS_BYTES = 2,
  parameter int          BLK_BYTES = 256,
  parameter logic [15:0] MANU_ID   = 16'h0089,
  parameter logic [15:0] CMDSET_ID = 16'h0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [2:0]        nbytes_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] shifted;
  nor_state_e        fsm_state;
  logic [7:0]        fsm_status;
  logic              do_prog;
  logic              do_erase;
  logic [31:0]       array_word;

  nor_addr_norm #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_norm (
    .addr_i(addr_i), .offset_o(offset), .shifted_o(shifted)
  );

  nor_cmd_fsm #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .nbytes_i(nbytes_i),
    .cmd_i(wdata_i[7:0]), .shifted_i(shifted), .state_o(fsm_state),
    .status_o(fsm_status), .prog_o(do_prog), .erase_o(do_erase)
  );

  nor_array #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .BLK_BYTES(BLK_BYTES)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_i(do_prog), .erase_i(do_erase),
    .offset_i(offset), .wdata_i(wdata_i), .word_o(array_word)
  );

  nor_read_mux #(
    .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .BLK_BYTES(BLK_BYTES),
    .MANU_ID(MANU_ID), .CMDSET_ID(CMDSET_ID)
  ) u_rmux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .state_i(fsm_state),
    .status_i(fsm_status), .shifted_i(shifted), .array_word_i(array_word),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk
  import nor_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int BUS_BYTES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        cmd_i,
  input logic [2:0]        nbytes_i,
  input logic [ADDR_W-1:0] shifted_i,
  input nor_state_e        state_i,
  input logic [7:0]        status_i,
  input logic              rvalid_i
);
  logic wr_ok;
  assign wr_ok = wr_en_i && (nbytes_i == 3'(BUS_BYTES));

  AST_READY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[SR_READY]); // R1
  AST_WIDTH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok) |=> ($stable(state_i) && $stable(status_i))); // R2
  AST_PROG_TO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && state_i == ST_PROG) |=> state_i == ST_STATUS); // R3
  AST_EXIT_TO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && state_i != ST_PROG && (cmd_i == CMD_READ_ARRAY || cmd_i == CMD_RESET))
    |=> state_i == ST_READ); // R4
  AST_QUERY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && state_i == ST_READ && cmd_i == CMD_QUERY && shifted_i != ADDR_W'(QUERY_ENTRY))
    |=> state_i == ST_READ); // R5
  AST_ERASE_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && state_i == ST_ERASE && cmd_i != CMD_CONFIRM && cmd_i != CMD_READ_ARRAY && cmd_i != CMD_RESET)
    |=> (status_i[SR_ERASE_ERR] && status_i[SR_PROG_ERR] && state_i == ST_STATUS)); // R7
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_i); // R12
  AST_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_i); // R12
endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .cmd_i(wdata_i[7:0]), .nbytes_i(nbytes_i), .shifted_i(shifted),
  .state_i(fsm_state), .status_i(fsm_status), .rvalid_i(rvalid_o)
);

// File: tb/nor_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [8:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [2:0]  nbytes_i = 3'd2;
  logic [31:0] rdata_o;
  logic        rvalid_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  nor_cmd_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .nbytes_i(nbytes_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // {op 1=wr 2=rd, addr, data, nbytes, expected, requirement number}
  localparam int NV = 48;
  localparam logic [59:0] VEC [NV] = '{
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'hFFFF, 8'd1},  // R1 erased array
    {4'd1, 12'h000, 16'h0040, 4'd2, 16'h0000, 8'd6},  // R6 program setup
    {4'd1, 12'h000, 16'h1234, 4'd2, 16'h0000, 8'd3},  // R3
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h0080, 8'd11}, // R11 status read
    {4'd1, 12'h000, 16'h00FF, 4'd2, 16'h0000, 8'd4},  // R4
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h1234, 8'd3},  // R3 little-endian
    {4'd1, 12'h000, 16'h0010, 4'd2, 16'h0000, 8'd6},  // R6 alt program code
    {4'd1, 12'h000, 16'hFF0F, 4'd2, 16'h0000, 8'd3},  // R3 AND only
    {4'd1, 12'h000, 16'h00F0, 4'd2, 16'h0000, 8'd4},  // R4 reset code
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h1204, 8'd3},  // R3
    {4'd1, 12'h000, 16'h0090, 4'd2, 16'h0000, 8'd5},  // R5 read id
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h0089, 8'd9},  // R9
    {4'd2, 12'h002, 16'h0000, 4'd2, 16'h00AD, 8'd9},  // R9
    {4'd2, 12'h004, 16'h0000, 4'd2, 16'h0000, 8'd9},  // R9
    {4'd2, 12'h00A, 16'h0000, 4'd2, 16'h8000, 8'd9},  // R9
    {4'd1, 12'h0AA, 16'h0098, 4'd2, 16'h0000, 8'd5},  // R5 entry at 0x55 (R12 shift)
    {4'd2, 12'h020, 16'h0000, 4'd2, 16'h0051, 8'd10}, // R10
    {4'd2, 12'h022, 16'h0000, 4'd2, 16'h0052, 8'd10}, // R10
    {4'd2, 12'h024, 16'h0000, 4'd2, 16'h0059, 8'd10}, // R10
    {4'd2, 12'h026, 16'h0000, 4'd2, 16'h0003, 8'd10}, // R10 cmdset id
    {4'd2, 12'h04E, 16'h0000, 4'd2, 16'h0009, 8'd10}, // R10 size exponent
    {4'd2, 12'h05A, 16'h0000, 4'd2, 16'h0001, 8'd10}, // R10 blocks-1
    {4'd2, 12'h05E, 16'h0000, 4'd2, 16'h0001, 8'd10}, // R10 block size/256
    {4'd2, 12'h062, 16'h0000, 4'd2, 16'h0000, 8'd10}, // R10 past end
    {4'd1, 12'h000, 16'h00FF, 4'd2, 16'h0000, 8'd4},  // R4
    {4'd1, 12'h000, 16'h0098, 4'd2, 16'h0000, 8'd5},  // R5 wrong address
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h1204, 8'd5},  // R5 still array read
    {4'd1, 12'h104, 16'h0040, 4'd2, 16'h0000, 8'd6},  // R6
    {4'd1, 12'h104, 16'hA5A5, 4'd2, 16'h0000, 8'd3},  // R3
    {4'd1, 12'h104, 16'h00FF, 4'd2, 16'h0000, 8'd4},  // R4
    {4'd2, 12'h104, 16'h0000, 4'd2, 16'hA5A5, 8'd3},  // R3
    {4'd1, 12'h1FE, 16'h0020, 4'd2, 16'h0000, 8'd6},  // R6 erase setup
    {4'd2, 12'h1FE, 16'h0000, 4'd2, 16'h0080, 8'd11}, // R11 erase-state read
    {4'd1, 12'h1FE, 16'h00D0, 4'd2, 16'h0000, 8'd7},  // R7 confirm
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h0080, 8'd7},  // R7 no errors
    {4'd1, 12'h000, 16'h00FF, 4'd2, 16'h0000, 8'd4},  // R4
    {4'd2, 12'h104, 16'h0000, 4'd2, 16'hFFFF, 8'd7},  // R7 block 1 erased
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h1204, 8'd7},  // R7 block 0 kept
    {4'd1, 12'h000, 16'h0020, 4'd2, 16'h0000, 8'd6},  // R6
    {4'd1, 12'h000, 16'h00AB, 4'd2, 16'h0000, 8'd7},  // R7 bad confirm
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h00B0, 8'd7},  // R7 both error bits
    {4'd1, 12'h000, 16'h0050, 4'd2, 16'h0000, 8'd6},  // R6 ignored in status
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h00B0, 8'd6},  // R6
    {4'd1, 12'h000, 16'h00FF, 4'd2, 16'h0000, 8'd4},  // R4
    {4'd1, 12'h000, 16'h0050, 4'd2, 16'h0000, 8'd6},  // R6 clear status
    {4'd1, 12'h000, 16'h0020, 4'd2, 16'h0000, 8'd6},  // R6
    {4'd2, 12'h000, 16'h0000, 4'd2, 16'h0080, 8'd6},  // R6 cleared
    {4'd1, 12'h000, 16'h00FF, 4'd2, 16'h0000, 8'd4}   // R4
  };

  task automatic wr(input logic [8:0] a, input logic [15:0] d, input logic [2:0] nb);
    @(negedge clk_i);
    addr_i = a; wdata_i = {16'h0, d}; nbytes_i = nb; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; nbytes_i = 3'd2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, input logic [15:0] e, input string req);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    chk(req, rdata_o, {16'h0, e});
    chk("R12", {31'h0, rvalid_o}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", {rdata_o[31:1], rvalid_o}, 32'h0);
    rst_ni = 1'b1;
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][59:56] == 4'd1)
        wr(VEC[k][52:44], VEC[k][43:28], VEC[k][26:24]);
      else
        rd(VEC[k][52:44], VEC[k][23:8], $sformatf("R%0d", VEC[k][7:0]));
    end
    // R12 pulse lasts one cycle
    @(negedge clk_i);
    chk("R12", {31'h0, rvalid_o}, 32'h0);
    // R8 lock setup paths
    wr(9'h000, 16'h0060, 3'd2); rd(9'h000, 16'h0000, "R11");
    wr(9'h000, 16'h0001, 3'd2); rd(9'h000, 16'h0080, "R8");
    wr(9'h000, 16'h00FF, 3'd2);
    wr(9'h000, 16'h0060, 3'd2); wr(9'h000, 16'h002F, 3'd2); rd(9'h000, 16'h0080, "R8");
    wr(9'h000, 16'h00FF, 3'd2);
    wr(9'h000, 16'h0060, 3'd2); wr(9'h000, 16'h00D0, 3'd2); rd(9'h000, 16'h0080, "R8");
    wr(9'h000, 16'h00FF, 3'd2); rd(9'h000, 16'h1204, "R8");
    wr(9'h000, 16'h0060, 3'd2); wr(9'h000, 16'h0033, 3'd2); rd(9'h000, 16'h00B0, "R8");
    wr(9'h000, 16'h00FF, 3'd2); wr(9'h000, 16'h0050, 3'd2);
    // R7 confirm clears earlier errors
    wr(9'h104, 16'h0020, 3'd2); wr(9'h104, 16'h00AB, 3'd2); wr(9'h104, 16'h00FF, 3'd2);
    wr(9'h104, 16'h0020, 3'd2); wr(9'h104, 16'h00D0, 3'd2); rd(9'h104, 16'h0080, "R7");
    wr(9'h000, 16'h00FF, 3'd2);
    // R2 wrong byte count ignored
    wr(9'h000, 16'h0090, 3'd1); rd(9'h000, 16'h1204, "R2");
    wr(9'h000, 16'h0040, 3'd2); wr(9'h000, 16'h0000, 3'd4);
    rd(9'h000, 16'h0000, "R2");
    wr(9'h000, 16'hFFFF, 3'd2); rd(9'h000, 16'h0080, "R3");
    wr(9'h000, 16'h00FF, 3'd2); rd(9'h000, 16'h1204, "R2");
    // R6 codes ignored in query state
    wr(9'h0AA, 16'h0098, 3'd2); wr(9'h0AA, 16'h0050, 3'd2); rd(9'h020, 16'h0051, "R6");
    wr(9'h000, 16'h00FF, 3'd2);
    // R1 reset mid-sequence
    wr(9'h000, 16'h0020, 3'd2); wr(9'h000, 16'h00AB, 3'd2);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(9'h000, 16'hFFFF, "R1");
    wr(9'h000, 16'h0020, 3'd2); rd(9'h000, 16'h0080, "R1");
    wr(9'h000, 16'h00FF, 3'd2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule